// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. At every rising clock edge it does one of four things. It loads an external base address. It steps a small internal beat counter. It holds the current address, which suspends the burst. Or, when a strobe arrives while the device is not selected, it goes idle. Two active-low start strobes can begin a burst: one driven by a processor and one by a memory controller. Either of them triggers a load when the select input is high.

Only the low two address bits are sequenced, so a burst is four beats long. The upper bits stay at the loaded base value, and after the fourth beat the low bits wrap back to their starting value. An ordering input chooses between two sequences. In linear order, each beat adds one modulo four. In interleaved order, beat k uses the starting low bits XOR k. The ordering input is captured at load time and stays fixed for the rest of that burst. A flag output marks the first beat of each burst.

Top module: `burst_addr_seq`

## Requirements
- R1: When `sel_i` is high and either `cpu_strobe_n_i` or `ctl_strobe_n_i` (or both) is low at a rising edge, `addr_o` equals `base_addr_i` after that edge and `first_beat_o` is 1.
- R2: A strobe low while `sel_i` is low loads nothing: `addr_o` keeps its value, `first_beat_o` goes to 0, and later advance pulses leave `addr_o` unchanged until the next load.
- R3: With both strobes high, `adv_n_i` low moves to the next burst address on that edge, and `adv_n_i` high keeps `addr_o` unchanged.
- R4: Stepping never changes bits 17..2 of `addr_o`. They stay at the loaded base value.
- R5: In linear order (ordering input 0 at load), each step sets the low two bits to the previous low two bits plus one, modulo 4.
- R6: In interleaved order (ordering input 1 at load), after k steps the low two bits equal the loaded low bits XOR (k mod 4).
- R7: The fourth step returns the low two bits to their loaded value, with no carry into bit 2.
- R8: A load in the middle of a burst restarts the sequence from the new base, with the beat count reset.
- R9: Changing `ilv_mode_i` during a burst has no effect on the order. Only its value at the load edge counts.
- R10: Synchronous reset `rst_i` sets `addr_o` to 0 and `first_beat_o` to 0, and leaves the sequencer idle, so advance pulses after reset do not move the address.
- R11: `first_beat_o` stays 1 through suspended cycles that follow a load and falls to 0 at the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Device select, active high |
| cpu_strobe_n_i | input | 1 | Processor start strobe, active low |
| ctl_strobe_n_i | input | 1 | Controller start strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low; high suspends |
| ilv_mode_i | input | 1 | Ordering: 0 linear, 1 interleaved (XOR) |
| base_addr_i | input | 18 | External base address |
| addr_o | output | 18 | Current burst word address |
| first_beat_o | output | 1 | High while the first beat of a burst is presented |

## Verification
The assertions assume that all inputs are settled and known at every rising edge, and that `rst_i` is asserted at time zero for at least one edge. The bench drives every input right after a clock edge and samples outputs one time unit after the following edge, so each command is stable across exactly one sampling edge. The sweep covers every starting low-bit value, both orderings and every strobe combination. It also toggles the ordering input on each step, so that a sampled mode is never confused with a live one.

// File: rtl/bas_pkg.sv
package bas_pkg;

    // Command decoded from the strobes, select and advance inputs
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_DESEL = 2'd3
    } bas_op_e;

    // Beat ordering captured at load time
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } bas_order_e;

endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
    import bas_pkg::*;
(
    input  logic    sel_i,
    input  logic    cpu_strobe_n_i,
    input  logic    ctl_strobe_n_i,
    input  logic    adv_n_i,
    output bas_op_e op_o
);

    logic any_strobe;

    always_comb begin
        any_strobe = !cpu_strobe_n_i || !ctl_strobe_n_i;
        if (any_strobe) begin
            op_o = sel_i ? OP_LOAD : OP_DESEL;
        end else if (!adv_n_i) begin
            op_o = OP_STEP;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/bas_order_gen.sv
module bas_order_gen
    import bas_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  bas_order_e        order_i,
    output logic [BEAT_W-1:0] low_o
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] xor_low;

    // Interleaved order: each bit is flipped by the matching beat bit
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign xor_low[b] = start_i[b] ^ beat_i[b];
    end

    // Linear order: modular add, carry out of the field is dropped
    always_comb begin
        lin_low = start_i + beat_i;
    end

    always_comb begin
        low_o = (order_i == ORD_XOR) ? xor_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sel_i,
    input  logic              cpu_strobe_n_i,
    input  logic              ctl_strobe_n_i,
    input  logic              adv_n_i,
    input  logic              ilv_mode_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              first_beat_o
);

    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        bas_order_e        order;
        logic              active;
        logic              first;
    } bas_state_t;

    bas_state_t        st_d;
    bas_state_t        st_q;
    bas_op_e           op;
    logic [BEAT_W-1:0] beat_nx;
    logic [BEAT_W-1:0] low_nx;

    bas_cmd_decode i_bas_cmd_decode (
        .sel_i          (sel_i),
        .cpu_strobe_n_i (cpu_strobe_n_i),
        .ctl_strobe_n_i (ctl_strobe_n_i),
        .adv_n_i        (adv_n_i),
        .op_o           (op)
    );

    always_comb begin
        beat_nx = st_q.beat + 1'b1;
    end

    bas_order_gen #(
        .BEAT_W (BEAT_W)
    ) i_bas_order_gen (
        .start_i (st_q.start),
        .beat_i  (beat_nx),
        .order_i (st_q.order),
        .low_o   (low_nx)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.addr   = base_addr_i;
                st_d.start  = base_addr_i[BEAT_W-1:0];
                st_d.beat   = '0;
                st_d.order  = bas_order_e'(ilv_mode_i);
                st_d.active = 1'b1;
                st_d.first  = 1'b1;
            end
            OP_DESEL: begin
                st_d.active = 1'b0;
                st_d.first  = 1'b0;
            end
            OP_STEP: begin
                if (st_q.active) begin
                    st_d.beat                = beat_nx;
                    st_d.addr[BEAT_W-1:0]    = low_nx;
                    st_d.first               = 1'b0;
                end
            end
            default: begin
                // suspend: every field keeps its value
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{addr: '0, start: '0, beat: '0, order: ORD_LINEAR,
                      active: 1'b0, first: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o       = st_q.addr;
    assign first_beat_o = st_q.first;

    // ---------------- assertions ----------------
    AST_LOAD_BASE: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i && (!cpu_strobe_n_i || !ctl_strobe_n_i))
        |=> (addr_o == $past(base_addr_i)) && first_beat_o); // R1

    AST_DESEL_NO_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sel_i && (!cpu_strobe_n_i || !ctl_strobe_n_i))
        |=> $stable(addr_o) && !first_beat_o); // R2

    AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_strobe_n_i && ctl_strobe_n_i && adv_n_i)
        |=> $stable(addr_o) && $stable(first_beat_o)); // R3

    AST_UPPER_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_strobe_n_i && ctl_strobe_n_i)
        |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R4

    AST_LINEAR_INC: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_strobe_n_i && ctl_strobe_n_i && !adv_n_i && st_q.active
         && (st_q.order == ORD_LINEAR))
        |=> addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)); // R5

    AST_STEP_CLEARS_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_strobe_n_i && ctl_strobe_n_i && !adv_n_i)
        |=> !first_beat_o); // R11

    AST_RESET_STATE: assert property (@(posedge clk_i)
        rst_i |=> (addr_o == '0) && !first_beat_o); // R10

    AST_HI_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.active && cpu_strobe_n_i && ctl_strobe_n_i && !adv_n_i)
        |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]))
            && (HI_W > 0)); // R7

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int ADDR_W = 18;

    logic              clk_i = 1'b0;
    logic              rst_i = 1'b1;
    logic              sel_i = 1'b0;
    logic              cpu_strobe_n_i = 1'b1;
    logic              ctl_strobe_n_i = 1'b1;
    logic              adv_n_i = 1'b1;
    logic              ilv_mode_i = 1'b0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic              first_beat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk_i = ~clk_i;

    burst_addr_seq i_burst_addr_seq (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .sel_i          (sel_i),
        .cpu_strobe_n_i (cpu_strobe_n_i),
        .ctl_strobe_n_i (ctl_strobe_n_i),
        .adv_n_i        (adv_n_i),
        .ilv_mode_i     (ilv_mode_i),
        .base_addr_i    (base_addr_i),
        .addr_o         (addr_o),
        .first_beat_o   (first_beat_o)
    );

    task automatic cyc();
        @(posedge clk_i);
        #1;
    endtask

    task automatic chk(input string req, input logic [ADDR_W-1:0] act_a,
                       input logic act_f, input logic [ADDR_W-1:0] exp_a,
                       input logic exp_f);
        checks++;
        if (act_a !== exp_a || act_f !== exp_f) begin
            fails++;
            $display("FAIL %s: addr=%h first=%b expected addr=%h first=%b",
                     req, act_a, act_f, exp_a, exp_f);
        end
    endtask

    task automatic idle_in();
        cpu_strobe_n_i = 1'b1;
        ctl_strobe_n_i = 1'b1;
        adv_n_i        = 1'b1;
    endtask

    task automatic do_load(input logic [ADDR_W-1:0] b, input logic m, input int which);
        sel_i          = 1'b1;
        base_addr_i    = b;
        ilv_mode_i     = m;
        adv_n_i        = 1'b1;
        cpu_strobe_n_i = (which == 1) ? 1'b1 : 1'b0;
        ctl_strobe_n_i = (which == 0) ? 1'b1 : 1'b0;
        cyc();
        idle_in();
    endtask

    task automatic do_step();
        adv_n_i = 1'b0;
        cyc();
        adv_n_i = 1'b1;
    endtask

    function automatic logic [1:0] exp_low(input int s, input int k, input int m);
        if (m != 0) return 2'((s ^ (k % 4)) & 3);
        return 2'((s + k) % 4);
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] b;
        logic [ADDR_W-1:0] keep;
        cyc(); cyc(); cyc();
        rst_i = 1'b0;
        // R10: reset state and no movement while idle
        chk("R10 reset", addr_o, first_beat_o, '0, 1'b0);
        do_step();
        chk("R10 idle advance", addr_o, first_beat_o, '0, 1'b0);

        // Sweep: ordering x start low bits x strobe combination
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int w = 0; w < 3; w++) begin
                    logic [15:0] up;
                    up = 16'(16'h1357 + m * 1111 + s * 97 + w * 13);
                    b  = {up, 2'(s)};
                    do_load(b, m[0], w);
                    chk("R1 load", addr_o, first_beat_o, b, 1'b1);
                    // R11/R3: suspend keeps address and first flag
                    cyc();
                    chk("R11 suspend first", addr_o, first_beat_o, b, 1'b1);
                    for (int k = 1; k <= 6; k++) begin
                        ilv_mode_i = ~ilv_mode_i; // R9: must be ignored
                        do_step();
                        if (k == 4)
                            chk("R7 wrap", addr_o, first_beat_o, b, 1'b0);
                        else if (m != 0)
                            chk("R6 interleaved R9", addr_o, first_beat_o,
                                {up, exp_low(s, k, m)}, 1'b0);
                        else
                            chk("R5 linear R4 R9", addr_o, first_beat_o,
                                {up, exp_low(s, k, m)}, 1'b0);
                        if (k == 2) begin
                            cyc();
                            chk("R3 hold", addr_o, first_beat_o,
                                {up, exp_low(s, k, m)}, 1'b0);
                        end
                    end
                end
            end
        end

        // R8: restart mid-burst
        do_load(18'h2A5F2, 1'b0, 0);
        do_step();
        do_step();
        do_load(18'h0C3C1, 1'b1, 1);
        chk("R8 restart load", addr_o, first_beat_o, 18'h0C3C1, 1'b1);
        do_step();
        chk("R8 restart step", addr_o, first_beat_o, 18'h0C3C0, 1'b0);
        do_step();
        chk("R8 restart step2", addr_o, first_beat_o, 18'h0C3C3, 1'b0);

        // R2: strobe while deselected
        keep = addr_o;
        sel_i = 1'b0;
        base_addr_i = 18'h3FFFF;
        cpu_strobe_n_i = 1'b0;
        cyc();
        idle_in();
        chk("R2 desel no load", addr_o, first_beat_o, keep, 1'b0);
        sel_i = 1'b1;
        do_step();
        chk("R2 desel idle step", addr_o, first_beat_o, keep, 1'b0);
        do_load(18'h00100, 1'b0, 2);
        chk("R2 reload after desel", addr_o, first_beat_o, 18'h00100, 1'b1);

        // R10: reset mid-burst
        do_step();
        rst_i = 1'b1;
        cyc();
        rst_i = 1'b0;
        chk("R10 reset mid burst", addr_o, first_beat_o, '0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule